// File: doc/BRIEF.md
# Phase-Frequency Detector with Charge-Pump Control

This block compares two divider pulses: one from the reference path and one from the feedback path. It turns their relative timing into pump-up, pump-down and drive-enable controls for an external charge pump. Each of the two detector flags sets on its own divider pulse. Once both flags are set, they stay set together for a fixed number of system-clock cycles and then clear at the same time. Every comparison cycle therefore drives both pump directions at least that long, which removes the dead zone when the loop is locked. Divider pulses are one-cycle strobes in the system-clock domain.

A polarity input selects which flag drives "up", so the block suits oscillators whose frequency rises or falls with control voltage. A high-impedance override silences the pump and also clears the comparator. With the override set, a test input switches the pump pin to carry a raw divider output. Power-down comes in two flavours. The immediate flavour silences the outputs in the same cycle. The deferred flavour first lets a pump pulse in progress finish.

Top module: `pfd_cp_ctrl`

## Requirements
- R1: After reset, pumpUp, pumpDown, pumpEn and testDrive are all 0.
- R2: With posPolarity = 1, a refPulse sets pumpUp from the next cycle onward. pumpUp holds until the detector clears.
- R3: Once both flags are set, pumpUp and pumpDown are both 1 for exactly MIN_PULSE cycles, then both return to 0 together. Simultaneous divider pulses (lock) produce exactly this overlap.
- R4: With posPolarity = 0, the refPulse flag drives pumpDown and the fbPulse flag drives pumpUp.
- R5: Divider pulses that arrive while the MIN_PULSE overlap window runs are dropped.
- R6: In normal operation pumpEn is 1 exactly when pumpUp or pumpDown is 1. A lagging reference (fbPulse first, posPolarity = 1) gives pumpDown alone.
- R7: While forceHiZ = 1 and testMode = 0, all four outputs are 0 and both detector flags are cleared. After release, the detector starts from an empty state.
- R8: With testMode = 1 and forceHiZ = 1, pumpEn = 1 and pumpUp = pumpDown = 0. testDrive then follows fbPulse when posPolarity = 1 and refPulse when posPolarity = 0, in the same cycle.
- R9: testMode = 1 with forceHiZ = 0 is an illegal pairing. All outputs stay 0 and the detector stays cleared.
- R10: pdReq = 1 with pdAsync = 1 forces all outputs to 0 in the same cycle. The detector is cleared at the next edge.
- R11: pdReq = 1 with pdAsync = 0 takes effect only at the first edge at which both flags are clear and no overlap window runs. Until then the pump pulse continues unchanged.
- R12: While powered down, divider pulses are ignored and outputs stay 0. When pdReq falls, operation resumes from cleared flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refPulse | input | 1 | One-cycle strobe from the reference divider |
| fbPulse | input | 1 | One-cycle strobe from the feedback divider |
| posPolarity | input | 1 | 1: reference flag drives up; 0: roles swapped |
| forceHiZ | input | 1 | Silence pump and clear comparator |
| testMode | input | 1 | Route a divider output to the pump pin (needs forceHiZ) |
| pdReq | input | 1 | Power-down request (level) |
| pdAsync | input | 1 | 1: immediate power-down; 0: wait for pulse end |
| pumpUp | output | 1 | Pump-up command |
| pumpDown | output | 1 | Pump-down command |
| pumpEn | output | 1 | Pump driver enable (0 = high impedance) |
| testDrive | output | 1 | Logic level on the pump pin in test routing |

## Verification
The assertions assume the divider inputs and the control levels are stable around each rising clock edge. They also assume reset is held for at least one edge before any property is evaluated. The stimulus changes every input only on falling edges and applies divider pulses as single-cycle strobes. The stimulus also visits the illegal test pairing on purpose, since the block defines a quiet response to it. Deferred power-down is requested while a flag is set, so the waiting path is exercised rather than only the idle case.

// File: rtl/pfd_cp_pkg.sv
package pfd_cp_pkg;
  typedef struct packed {
    logic accept;      // detector flags may take new divider pulses
    logic clearFlags;  // drop both flags at next edge
    logic gateOff;     // power-down in force: silence outputs now
  } pfdStrobe_t;
endpackage

// File: rtl/pfd_cp_ctrl_fsm.sv
module pfd_cp_ctrl_fsm
  import pfd_cp_pkg::*;
#(
  parameter int MIN_PULSE = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refPulse,
  input  logic       fbPulse,
  input  logic       forceHiZ,
  input  logic       testMode,
  input  logic       pdReq,
  input  logic       pdAsync,
  input  logic       refFlag,
  input  logic       fbFlag,
  output pfdStrobe_t strobe
);
  localparam int CNT_W = $clog2(MIN_PULSE + 1);
  localparam logic [CNT_W-1:0] WIN_LOAD = CNT_W'(MIN_PULSE);

  logic [CNT_W-1:0] winCnt;
  logic sleepQ;
  logic asyncNow, hold, winActive, lastWin, bothNext, idleNow;

  always_comb begin
    asyncNow  = pdReq & pdAsync;
    hold      = forceHiZ | testMode | sleepQ | asyncNow;
    winActive = (winCnt != '0);
    lastWin   = (winCnt == CNT_W'(1));
    bothNext  = (refFlag | refPulse) & (fbFlag | fbPulse);
    idleNow   = ~refFlag & ~fbFlag & ~winActive;
    strobe.accept     = ~hold & ~winActive;
    strobe.clearFlags = hold | lastWin;
    strobe.gateOff    = sleepQ | asyncNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt <= '0;
      sleepQ <= 1'b0;
    end else begin
      sleepQ <= pdReq & (pdAsync | sleepQ | idleNow);
      if (hold)           winCnt <= '0;
      else if (winActive) winCnt <= winCnt - 1'b1;
      else if (bothNext)  winCnt <= WIN_LOAD;
    end
  end

  AST_WIN_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (lastWin && !hold) |=> (!refFlag && !fbFlag)); // R3
  AST_ASYNC_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    (pdReq && pdAsync) |=> (sleepQ && !refFlag && !fbFlag)); // R10
  AST_SYNC_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (pdReq && !pdAsync && !sleepQ && (refFlag || fbFlag)) |=> !sleepQ); // R11
  AST_HIZ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    forceHiZ |=> (!refFlag && !fbFlag && winCnt == '0)); // R7
endmodule

// File: rtl/pfd_cp_core.sv
module pfd_cp_core
  import pfd_cp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       refPulse,
  input  logic       fbPulse,
  input  logic       posPolarity,
  input  logic       forceHiZ,
  input  logic       testMode,
  input  pfdStrobe_t strobe,
  output logic       refFlag,
  output logic       fbFlag,
  output logic       pumpUp,
  output logic       pumpDown,
  output logic       pumpEn,
  output logic       testDrive
);
  logic normalRun, testRoute, upRaw, downRaw;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refFlag <= 1'b0;
      fbFlag  <= 1'b0;
    end else if (strobe.clearFlags) begin
      refFlag <= 1'b0;
      fbFlag  <= 1'b0;
    end else if (strobe.accept) begin
      refFlag <= refFlag | refPulse;
      fbFlag  <= fbFlag | fbPulse;
    end
  end

  always_comb begin
    normalRun = ~strobe.gateOff & ~forceHiZ & ~testMode;
    testRoute = ~strobe.gateOff & forceHiZ & testMode;
    upRaw     = posPolarity ? refFlag : fbFlag;
    downRaw   = posPolarity ? fbFlag : refFlag;
    pumpUp    = normalRun & upRaw;
    pumpDown  = normalRun & downRaw;
    pumpEn    = testRoute | pumpUp | pumpDown;
    testDrive = testRoute & (posPolarity ? fbPulse : refPulse);
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (refFlag && !strobe.clearFlags) |=> refFlag); // R2
  AST_TEST_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    testMode |-> (!pumpUp && !pumpDown)); // R8
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.gateOff |-> (!pumpEn && !testDrive)); // R10
  AST_PAUSE_NO_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.accept && !refFlag) |=> !refFlag); // R5
endmodule

// File: rtl/pfd_cp_ctrl.sv
module pfd_cp_ctrl
  import pfd_cp_pkg::*;
#(
  parameter int MIN_PULSE = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic refPulse,
  input  logic fbPulse,
  input  logic posPolarity,
  input  logic forceHiZ,
  input  logic testMode,
  input  logic pdReq,
  input  logic pdAsync,
  output logic pumpUp,
  output logic pumpDown,
  output logic pumpEn,
  output logic testDrive
);
  pfdStrobe_t strobe;
  logic refFlag, fbFlag;

  pfd_cp_ctrl_fsm #(.MIN_PULSE(MIN_PULSE)) uCtrl (
    .clk(clk), .rstN(rstN), .refPulse(refPulse), .fbPulse(fbPulse),
    .forceHiZ(forceHiZ), .testMode(testMode), .pdReq(pdReq),
    .pdAsync(pdAsync), .refFlag(refFlag), .fbFlag(fbFlag), .strobe(strobe)
  );

  pfd_cp_core uCore (
    .clk(clk), .rstN(rstN), .refPulse(refPulse), .fbPulse(fbPulse),
    .posPolarity(posPolarity), .forceHiZ(forceHiZ), .testMode(testMode),
    .strobe(strobe), .refFlag(refFlag), .fbFlag(fbFlag),
    .pumpUp(pumpUp), .pumpDown(pumpDown), .pumpEn(pumpEn),
    .testDrive(testDrive)
  );

  AST_EN_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    (!testMode && !forceHiZ) |-> (pumpEn == (pumpUp || pumpDown))); // R6
endmodule

// File: tb/tb_pfd_cp_ctrl.sv
module tb_pfd_cp_ctrl;
  localparam int MINP = 3;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refPulse = 0, fbPulse = 0, posPolarity = 1, forceHiZ = 0;
  logic testMode = 0, pdReq = 0, pdAsync = 0;
  logic pumpUp, pumpDown, pumpEn, testDrive;

  int total = 0, fails = 0, overlapCnt = 0;
  string phase = "R1";
  bit finished = 0;

  // behavioural reference state
  bit mRef = 0, mFb = 0, mSleep = 0;
  int mWin = 0;

  always #2.5 clk = ~clk;

  pfd_cp_ctrl #(.MIN_PULSE(MINP)) dut (
    .clk(clk), .rstN(rstN), .refPulse(refPulse), .fbPulse(fbPulse),
    .posPolarity(posPolarity), .forceHiZ(forceHiZ), .testMode(testMode),
    .pdReq(pdReq), .pdAsync(pdAsync), .pumpUp(pumpUp), .pumpDown(pumpDown),
    .pumpEn(pumpEn), .testDrive(testDrive)
  );

  always @(posedge clk) begin
    bit asyncNow, holdNow, nextSleep;
    if (!rstN) begin
      mRef = 0; mFb = 0; mWin = 0; mSleep = 0;
    end else begin
      asyncNow  = pdReq && pdAsync;
      holdNow   = forceHiZ || testMode || mSleep || asyncNow;
      nextSleep = pdReq && (pdAsync || mSleep || (!mRef && !mFb && mWin == 0));
      if (holdNow) begin
        mRef = 0; mFb = 0; mWin = 0;
      end else if (mWin > 0) begin
        if (mWin == 1) begin mRef = 0; mFb = 0; end
        mWin = mWin - 1;
      end else begin
        mRef = mRef || refPulse;
        mFb  = mFb || fbPulse;
        if (mRef && mFb) mWin = MINP;
      end
      mSleep = nextSleep;
    end
  end

  task automatic checkBit(string tag, string name, logic act, logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, name, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit off, route, normal, eUp, eDn, eEn, eTd;
    off    = mSleep || (pdReq && pdAsync);
    route  = !off && forceHiZ && testMode;
    normal = !off && !forceHiZ && !testMode;
    eUp = normal && (posPolarity ? mRef : mFb);
    eDn = normal && (posPolarity ? mFb : mRef);
    eEn = route || eUp || eDn;
    eTd = route && (posPolarity ? fbPulse : refPulse);
    checkBit(phase, "pumpUp", pumpUp, eUp);
    checkBit(phase, "pumpDown", pumpDown, eDn);
    checkBit(phase, "pumpEn", pumpEn, eEn);
    checkBit(phase, "testDrive", testDrive, eTd);
    if (pumpUp && pumpDown) overlapCnt++;
  endtask

  task automatic cyc(int n);
    repeat (n) begin @(negedge clk); compare(); end
  endtask

  task automatic pulse(bit r, bit f);
    refPulse = r; fbPulse = f;
    cyc(1);
    refPulse = 0; fbPulse = 0;
  endtask

  initial begin
    #500us;
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    phase = "R1";
    checkBit("R1", "pumpUp", pumpUp, 0);
    checkBit("R1", "pumpDown", pumpDown, 0);
    checkBit("R1", "pumpEn", pumpEn, 0);
    checkBit("R1", "testDrive", testDrive, 0);

    phase = "R2"; pulse(1, 0); cyc(4); pulse(0, 1); cyc(6);

    phase = "R3"; overlapCnt = 0; pulse(1, 1); cyc(6);
    checkBit("R3", "overlap==MIN", overlapCnt == MINP, 1);

    phase = "R4"; posPolarity = 0; pulse(1, 0); cyc(3); pulse(0, 1); cyc(6);
    posPolarity = 1;

    phase = "R5"; pulse(1, 1); pulse(1, 0); pulse(0, 1); cyc(6);

    phase = "R6"; pulse(0, 1); cyc(3); pulse(1, 0); cyc(6);

    phase = "R7"; pulse(1, 0); cyc(2); forceHiZ = 1; cyc(3); forceHiZ = 0;
    pulse(0, 1); cyc(3);
    checkBit("R7", "down only after release", pumpDown && !pumpUp, 1);
    pulse(1, 0); cyc(6);

    phase = "R8"; forceHiZ = 1; testMode = 1; cyc(1);
    pulse(0, 1); pulse(1, 0); cyc(1);
    posPolarity = 0; pulse(1, 0); pulse(0, 1); pulse(1, 1); cyc(1);
    posPolarity = 1; testMode = 0; forceHiZ = 0; cyc(2);

    phase = "R9"; testMode = 1; pulse(1, 0); pulse(0, 1); cyc(3);
    testMode = 0; cyc(2);

    phase = "R10"; pulse(1, 0); cyc(2); pdAsync = 1; pdReq = 1;
    #0; compare();
    pulse(0, 1); cyc(3); pdReq = 0; pdAsync = 0; cyc(2);

    phase = "R11"; pulse(1, 0); cyc(1); pdReq = 1; cyc(3);
    pulse(0, 1); cyc(MINP + 3);

    phase = "R12"; pulse(1, 1); pulse(0, 1); cyc(2); pdReq = 0; cyc(1);
    pulse(0, 1); cyc(2);
    checkBit("R12", "fresh start down only", pumpDown && !pumpUp, 1);
    pulse(1, 0); cyc(6);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule